// File: doc/BRIEF.md
# Ternary Flow Classifier with Exact-Match Merge

This block keeps a small table of flow rules, each a key pattern with a per-bit care mask, and compares every incoming flow key against all rules at once. The comparison is split into eight 32-bit slices. A rule matches only when each slice agrees on every bit its mask marks as cared-for, and the rule is enabled. An exact-match engine outside the block runs its own lookup on the same packets and reports a hit or miss, together with an action, through a separate input.

Both results go into small queues and are paired in arrival order. A two-state machine merges each pair into one verdict: forward to a set of ports, send to the controller, or drop. When the verdict comes from a table rule, that rule's saturating packet counter is incremented. Software loads rules through a word-wide register port. Value, mask and action words go into staging registers first. A single commit write then copies the whole rule into an entry in one edge.

The arbiter has two states. ARB_COLLECT waits and moves to ARB_RESOLVE when both queues hold a result. ARB_RESOLVE pops both queues, registers the verdict and bumps the counter, then always returns to ARB_COLLECT.

Top module: `wild_flow_classifier`

## Requirements
- R1: After reset, dec_valid and cfg_rvalid are low, every entry is disabled, and every counter reads 0.
- R2: Key bits [32k+31:32k] form slice k (k = 0..7). Mask bit 1 compares the key bit with the stored value and mask bit 0 ignores it. An entry matches only if all eight slices match.
- R3: An entry committed with its enable bit clear never matches, even if every mask bit is 0.
- R4: When several enabled entries match, the lowest-numbered entry supplies the verdict.
- R5: An exact-match hit overrides any table hit. The verdict then carries the exact-match action, with dec_wild=0 and dec_entry=0.
- R6: A key that misses in both lookups yields kind 2 (controller), ports 0, dec_wild=0 and dec_entry=0.
- R7: Results are paired strictly in arrival order, and each pair gives exactly one verdict. dec_valid is high for one cycle, starting two clock edges after the edge that accepts the later result of the pair.
- R8: Action kind is encoded as 0 for drop, 1 for forward and 2 for controller. A table winner reports its stored kind and port set, and dec_entry gives its index.
- R9: A cfg_rd gives cfg_rvalid and cfg_rdata one edge later. For field 18, cfg_rdata is the entry's counter. The counter goes up by one only when that entry wins and there is no exact-match hit.
- R10: A counter stops at all-ones. A write to field 18 loads the counter with cfg_wdata, so writing 0 clears it.
- R11: A commit and a lookup on the same edge: the lookup uses the old entry contents. Later lookups use the new contents.
- R12: cfg_addr is {entry[4:0], field[4:0]}. Fields 0-7 stage value slice k, fields 8-15 stage mask slice k-8, and field 16 stages the action as {ports[5:2], kind[1:0]}. Field 17 commits the staged rule to the entry, with wdata[0] as the enable bit. Staging alone does not change lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Flow key present this cycle |
| key_data | input | 256 | Flow key, eight 32-bit slices |
| exm_valid | input | 1 | Exact-match result present |
| exm_hit | input | 1 | Exact-match engine found the flow |
| exm_kind | input | 2 | Exact-match action kind |
| exm_ports | input | 4 | Exact-match output port set |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 10 | {entry, field} |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data |
| cfg_rvalid | output | 1 | Read data valid |
| dec_valid | output | 1 | Verdict valid (one cycle) |
| dec_kind | output | 2 | Verdict action kind |
| dec_ports | output | 4 | Verdict port set |
| dec_wild | output | 1 | Verdict came from a table entry |
| dec_entry | output | 5 | Winning table entry index |

## Verification
The table lookup is registered into the queue on the edge that accepts the key. The machine reaches ARB_RESOLVE one edge later, and the verdict registers on the edge after that. So when both inputs arrive together, dec_valid is checked low after the first following edge and high after the second. Counter reads are sampled just after the edge that follows the read strobe. The ordering test and the same-edge commit test wait a bounded number of cycles for each verdict and check that verdicts come out in order.

// File: rtl/wfc_pkg.sv
package wfc_pkg;
    typedef enum logic [1:0] {
        ACT_DROP = 2'd0,
        ACT_FWD  = 2'd1,
        ACT_CTRL = 2'd2,
        ACT_RSV  = 2'd3
    } act_kind_e;

    typedef enum logic {
        ARB_COLLECT = 1'b0,
        ARB_RESOLVE = 1'b1
    } arb_state_e;
endpackage

// File: rtl/wfc_tcam_slice.sv
module wfc_tcam_slice #(
    parameter int ENTRIES = 32,
    parameter int WIDTH   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WIDTH-1:0]   wr_val,
    input  logic [WIDTH-1:0]   wr_msk,
    input  logic [WIDTH-1:0]   key_part,
    output logic [ENTRIES-1:0] hits
);
    logic [WIDTH-1:0] val_q [ENTRIES];
    logic [WIDTH-1:0] msk_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            val_q[wr_idx] <= wr_val & wr_msk;
            msk_q[wr_idx] <= wr_msk;
        end
    end

    // Each entry compares only the bits its mask cares about.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hits[e] = (((key_part ^ val_q[e]) & msk_q[e]) == '0);
    end
endmodule

// File: rtl/wfc_table.sv
module wfc_table #(
    parameter int ENTRIES = 32,
    parameter int SLICES  = 8,
    parameter int SLICE_W = 32,
    parameter int NPORTS  = 4,
    parameter int CFG_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int FLD_W  = $clog2(2*SLICES+3),
    localparam int KEY_W  = SLICES*SLICE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_entry,
    input  logic [FLD_W-1:0]  cfg_field,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [KEY_W-1:0]  key,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [1:0]        hit_kind,
    output logic [NPORTS-1:0] hit_ports
);
    localparam int FLD_ACT    = 2*SLICES;
    localparam int FLD_COMMIT = 2*SLICES+1;

    logic [SLICE_W-1:0] stg_val [SLICES];
    logic [SLICE_W-1:0] stg_msk [SLICES];
    logic [1:0]         stg_kind;
    logic [NPORTS-1:0]  stg_ports;

    logic [ENTRIES-1:0] ena_q;
    logic [1:0]         kind_q  [ENTRIES];
    logic [NPORTS-1:0]  ports_q [ENTRIES];

    logic                             commit;
    logic [SLICES-1:0][ENTRIES-1:0]   slice_hits;
    logic [ENTRIES-1:0]               all_hits;

    assign commit = cfg_wr && (cfg_field == FLD_W'(FLD_COMMIT));

    always_ff @(posedge clk) begin
        for (int s = 0; s < SLICES; s++) begin
            if (cfg_wr && cfg_field == FLD_W'(s))
                stg_val[s] <= SLICE_W'(cfg_wdata);
            if (cfg_wr && cfg_field == FLD_W'(SLICES+s))
                stg_msk[s] <= SLICE_W'(cfg_wdata);
        end
        if (cfg_wr && cfg_field == FLD_W'(FLD_ACT)) begin
            stg_kind  <= cfg_wdata[1:0];
            stg_ports <= cfg_wdata[2 +: NPORTS];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (commit) begin
            ena_q[cfg_entry]   <= cfg_wdata[0];
            kind_q[cfg_entry]  <= stg_kind;
            ports_q[cfg_entry] <= stg_ports;
        end
    end

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        wfc_tcam_slice #(.ENTRIES(ENTRIES), .WIDTH(SLICE_W)) u_slice (
            .clk      (clk),
            .wr_en    (commit),
            .wr_idx   (cfg_entry),
            .wr_val   (stg_val[s]),
            .wr_msk   (stg_msk[s]),
            .key_part (key[s*SLICE_W +: SLICE_W]),
            .hits     (slice_hits[s])
        );
    end

    always_comb begin
        all_hits = ena_q;
        for (int s = 0; s < SLICES; s++)
            all_hits = all_hits & slice_hits[s];
    end

    // Lowest index wins: scan downward so the last assignment is the smallest.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int e = ENTRIES-1; e >= 0; e--) begin
            if (all_hits[e]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(e);
            end
        end
    end

    assign hit_kind  = kind_q[hit_idx];
    assign hit_ports = ports_q[hit_idx];
endmodule

// File: rtl/wfc_pair_fifo.sv
module wfc_pair_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/wfc_arbiter.sv
module wfc_arbiter
    import wfc_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_empty,
    input  logic              w_hit,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [1:0]        w_kind,
    input  logic [NPORTS-1:0] w_ports,
    input  logic              x_empty,
    input  logic              x_hit,
    input  logic [1:0]        x_kind,
    input  logic [NPORTS-1:0] x_ports,
    output logic              pop,
    output logic              bump_en,
    output logic [IDX_W-1:0]  bump_idx,
    output logic              dec_valid,
    output logic [1:0]        dec_kind,
    output logic [NPORTS-1:0] dec_ports,
    output logic              dec_wild,
    output logic [IDX_W-1:0]  dec_entry
);
    arb_state_e state_q, state_d;

    logic [1:0]        sel_kind;
    logic [NPORTS-1:0] sel_ports;
    logic              sel_wild;
    logic [IDX_W-1:0]  sel_entry;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_COLLECT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_COLLECT: if (!w_empty && !x_empty) state_d = ARB_RESOLVE;
            ARB_RESOLVE: state_d = ARB_COLLECT;
        endcase
    end

    // Exact hit first, then table hit, otherwise hand to the controller.
    always_comb begin
        sel_wild  = 1'b0;
        sel_entry = '0;
        if (x_hit) begin
            sel_kind  = x_kind;
            sel_ports = x_ports;
        end else if (w_hit) begin
            sel_kind  = w_kind;
            sel_ports = w_ports;
            sel_wild  = 1'b1;
            sel_entry = w_idx;
        end else begin
            sel_kind  = ACT_CTRL;
            sel_ports = '0;
        end
    end

    assign pop      = (state_q == ARB_RESOLVE);
    assign bump_en  = pop && sel_wild;
    assign bump_idx = w_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_kind  <= '0;
            dec_ports <= '0;
            dec_wild  <= 1'b0;
            dec_entry <= '0;
        end else begin
            dec_valid <= pop;
            if (pop) begin
                dec_kind  <= sel_kind;
                dec_ports <= sel_ports;
                dec_wild  <= sel_wild;
                dec_entry <= sel_entry;
            end
        end
    end
endmodule

// File: rtl/wfc_hit_counters.sv
module wfc_hit_counters #(
    parameter int ENTRIES = 32,
    parameter int CNT_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_en,
    input  logic [IDX_W-1:0] bump_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_data
);
    logic [CNT_W-1:0] cnt_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[e] <= '0;
            else if (wr_en && wr_idx == IDX_W'(e))
                cnt_q[e] <= wr_data;
            else if (bump_en && bump_idx == IDX_W'(e) && cnt_q[e] != '1)
                cnt_q[e] <= cnt_q[e] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= cnt_q[rd_idx];
        else            rd_data <= '0;
    end
endmodule

// File: rtl/wild_flow_classifier.sv
module wild_flow_classifier #(
    parameter int ENTRIES = 32,
    parameter int SLICES  = 8,
    parameter int SLICE_W = 32,
    parameter int NPORTS  = 4,
    parameter int CNT_W   = 32,
    parameter int CFG_W   = 32,
    parameter int QDEPTH  = 4,
    localparam int KEY_W  = SLICES*SLICE_W,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int FLD_W  = $clog2(2*SLICES+3),
    localparam int ADDR_W = IDX_W+FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [KEY_W-1:0]  key_data,
    input  logic              exm_valid,
    input  logic              exm_hit,
    input  logic [1:0]        exm_kind,
    input  logic [NPORTS-1:0] exm_ports,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              cfg_rvalid,
    output logic              dec_valid,
    output logic [1:0]        dec_kind,
    output logic [NPORTS-1:0] dec_ports,
    output logic              dec_wild,
    output logic [IDX_W-1:0]  dec_entry
);
    localparam int FLD_CNT = 2*SLICES+2;
    localparam int WQ_W    = 1+IDX_W+2+NPORTS;
    localparam int XQ_W    = 1+2+NPORTS;

    logic [IDX_W-1:0]  cfg_entry;
    logic [FLD_W-1:0]  cfg_field;
    logic              cnt_sel;

    logic              t_hit;
    logic [IDX_W-1:0]  t_idx;
    logic [1:0]        t_kind;
    logic [NPORTS-1:0] t_ports;

    logic [WQ_W-1:0]   wq_dout;
    logic [XQ_W-1:0]   xq_dout;
    logic              wq_empty, xq_empty, wq_full, xq_full;
    logic              pop, bump_en;
    logic [IDX_W-1:0]  bump_idx;
    logic [CNT_W-1:0]  cnt_rd;

    assign cfg_entry = cfg_addr[ADDR_W-1:FLD_W];
    assign cfg_field = cfg_addr[FLD_W-1:0];
    assign cnt_sel   = (cfg_field == FLD_W'(FLD_CNT));

    wfc_table #(
        .ENTRIES(ENTRIES), .SLICES(SLICES), .SLICE_W(SLICE_W),
        .NPORTS(NPORTS), .CFG_W(CFG_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_entry (cfg_entry),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .key       (key_data),
        .hit       (t_hit),
        .hit_idx   (t_idx),
        .hit_kind  (t_kind),
        .hit_ports (t_ports)
    );

    wfc_pair_fifo #(.WIDTH(WQ_W), .DEPTH(QDEPTH)) u_wq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (key_valid),
        .din   ({t_hit, t_idx, t_kind, t_ports}),
        .pop   (pop),
        .dout  (wq_dout),
        .empty (wq_empty),
        .full  (wq_full)
    );

    wfc_pair_fifo #(.WIDTH(XQ_W), .DEPTH(QDEPTH)) u_xq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (exm_valid),
        .din   ({exm_hit, exm_kind, exm_ports}),
        .pop   (pop),
        .dout  (xq_dout),
        .empty (xq_empty),
        .full  (xq_full)
    );

    wfc_arbiter #(.NPORTS(NPORTS), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .w_empty   (wq_empty),
        .w_hit     (wq_dout[WQ_W-1]),
        .w_idx     (wq_dout[NPORTS+2 +: IDX_W]),
        .w_kind    (wq_dout[NPORTS +: 2]),
        .w_ports   (wq_dout[NPORTS-1:0]),
        .x_empty   (xq_empty),
        .x_hit     (xq_dout[XQ_W-1]),
        .x_kind    (xq_dout[NPORTS +: 2]),
        .x_ports   (xq_dout[NPORTS-1:0]),
        .pop       (pop),
        .bump_en   (bump_en),
        .bump_idx  (bump_idx),
        .dec_valid (dec_valid),
        .dec_kind  (dec_kind),
        .dec_ports (dec_ports),
        .dec_wild  (dec_wild),
        .dec_entry (dec_entry)
    );

    wfc_hit_counters #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .bump_en  (bump_en),
        .bump_idx (bump_idx),
        .wr_en    (cfg_wr && cnt_sel),
        .wr_idx   (cfg_entry),
        .wr_data  (CNT_W'(cfg_wdata)),
        .rd_en    (cfg_rd && cnt_sel),
        .rd_idx   (cfg_entry),
        .rd_data  (cnt_rd)
    );

    assign cfg_rdata = CFG_W'(cnt_rd);

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_rvalid <= 1'b0;
        else        cfg_rvalid <= cfg_rd;
    end
endmodule

// File: rtl/wfc_checker.sv
module wfc_checker #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_valid,
    input logic             dec_wild,
    input logic [IDX_W-1:0] dec_entry,
    input logic             cfg_rd,
    input logic             cfg_rvalid,
    input logic             wq_empty,
    input logic             xq_empty
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dec_valid); // R1

    AST_DEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid); // R7

    AST_DEC_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(!wq_empty && !xq_empty)); // R7

    AST_NONWILD_ENTRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_wild) |-> (dec_entry == '0)); // R5

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> cfg_rvalid); // R9

    AST_READ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> $past(cfg_rd)); // R9
endmodule

bind wild_flow_classifier wfc_checker #(.IDX_W(IDX_W)) u_wfc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_wild   (dec_wild),
    .dec_entry  (dec_entry),
    .cfg_rd     (cfg_rd),
    .cfg_rvalid (cfg_rvalid),
    .wq_empty   (wq_empty),
    .xq_empty   (xq_empty)
);

// File: tb/test_wild_flow_classifier.sv
module test_wild_flow_classifier;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_valid = 1'b0;
    logic [255:0] key_data = '0;
    logic         exm_valid = 1'b0;
    logic         exm_hit = 1'b0;
    logic [1:0]   exm_kind = '0;
    logic [3:0]   exm_ports = '0;
    logic         cfg_wr = 1'b0;
    logic         cfg_rd = 1'b0;
    logic [9:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [31:0]  cfg_rdata;
    logic         cfg_rvalid;
    logic         dec_valid;
    logic [1:0]   dec_kind;
    logic [3:0]   dec_ports;
    logic         dec_wild;
    logic [4:0]   dec_entry;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wild_flow_classifier i_wild_flow_classifier (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_data(key_data),
        .exm_valid(exm_valid), .exm_hit(exm_hit), .exm_kind(exm_kind), .exm_ports(exm_ports),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .dec_valid(dec_valid),
        .dec_kind(dec_kind), .dec_ports(dec_ports), .dec_wild(dec_wild), .dec_entry(dec_entry)
    );

    // Row: {key sel[3], xhit, xkind[2], xports[4], ekind[2], eports[4], ewild, eentry[5]}
    localparam logic [21:0] VEC [9] = '{
        {3'd0, 1'b0, 2'd0, 4'h0, 2'd1, 4'h5, 1'b1, 5'd3},
        {3'd1, 1'b0, 2'd0, 4'h0, 2'd2, 4'h0, 1'b0, 5'd0},
        {3'd2, 1'b0, 2'd0, 4'h0, 2'd0, 4'h0, 1'b1, 5'd5},
        {3'd3, 1'b0, 2'd0, 4'h0, 2'd1, 4'h8, 1'b1, 5'd1},
        {3'd0, 1'b1, 2'd1, 4'h2, 2'd1, 4'h2, 1'b0, 5'd0},
        {3'd1, 1'b1, 2'd0, 4'h0, 2'd0, 4'h0, 1'b0, 5'd0},
        {3'd4, 1'b0, 2'd0, 4'h0, 2'd2, 4'h0, 1'b0, 5'd0},
        {3'd0, 1'b1, 2'd2, 4'hF, 2'd2, 4'hF, 1'b0, 5'd0},
        {3'd3, 1'b0, 2'd0, 4'h0, 2'd1, 4'h8, 1'b1, 5'd1}
    };

    function automatic string req_of(input int i);
        case (i)
            0: return "R2 R8";
            1: return "R2 R3 R6";
            2: return "R8";
            3: return "R4";
            4, 5, 7: return "R5";
            6: return "R2";
            default: return "R4 R8";
        endcase
    endfunction

    function automatic logic [255:0] key_of(input int sel);
        logic [255:0] k;
        k = '0;
        if (sel == 0 || sel == 1 || sel == 4) begin
            for (int s = 0; s < 8; s++) k[s*32 +: 32] = 32'hA0A0_0000 + 32'(s);
            k[31:0] = (sel == 4) ? 32'hA0A1_1234 : 32'hA0A0_1234;
            if (sel == 1) k[4*32 +: 32] = k[4*32 +: 32] ^ 32'h0000_0100;
        end else begin
            k[7*32 +: 32] = 32'h0000_0077;
            if (sel == 3) k[6*32 +: 32] = 32'h0000_BEEF;
        end
        return k;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic cfg_write(input int idx, input int fld, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = {5'(idx), 5'(fld)}; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cnt_read(input int idx, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = {5'(idx), 5'd18};
        @(posedge clk); #1;
        check("R9 rvalid", 64'(cfg_rvalid), 64'd1);
        d = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic stage(input logic [31:0] v [8], input logic [31:0] m [8],
                         input logic [1:0] kind, input logic [3:0] ports);
        for (int s = 0; s < 8; s++) begin
            cfg_write(0, s, v[s]);
            cfg_write(0, 8 + s, m[s]);
        end
        cfg_write(0, 16, {26'd0, ports, kind});
    endtask

    task automatic send(input logic [255:0] k, input logic xh, input logic [1:0] xk,
                        input logic [3:0] xp);
        @(negedge clk);
        key_valid = 1'b1; key_data = k;
        exm_valid = 1'b1; exm_hit = xh; exm_kind = xk; exm_ports = xp;
        @(negedge clk);
        key_valid = 1'b0; exm_valid = 1'b0;
    endtask

    task automatic collect(output logic [1:0] k, output logic [3:0] p,
                           output logic w, output logic [4:0] e);
        bit got = 0;
        for (int c = 0; c < 20 && !got; c++) begin
            @(posedge clk); #1;
            if (dec_valid) begin
                got = 1; k = dec_kind; p = dec_ports; w = dec_wild; e = dec_entry;
            end
        end
        check("R7 verdict arrives", 64'(got), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] v [8];
        logic [31:0] m [8];
        logic [31:0] rd;
        logic [1:0]  k;
        logic [3:0]  p;
        logic        w;
        logic [4:0]  e;
        bit          seen;

        repeat (3) @(posedge clk);
        #1;
        check("R1 dec_valid in reset", 64'(dec_valid), 64'd0);
        check("R1 rvalid in reset", 64'(cfg_rvalid), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        cnt_read(0, rd);
        check("R1 counter zero", 64'(rd), 64'd0);
        send(key_of(0), 1'b0, 2'd0, 4'h0);
        collect(k, p, w, e);
        check("R1 empty table gives controller", {k, p, w, e}, {2'd2, 4'h0, 1'b0, 5'd0});

        // Entry 3: slice k = A0A0_0000+k, slice 0 low half ignored; forward 0101
        for (int s = 0; s < 8; s++) begin v[s] = 32'hA0A0_0000 + 32'(s); m[s] = '1; end
        m[0] = 32'hFFFF_0000;
        stage(v, m, 2'd1, 4'h5); cfg_write(3, 17, 32'd1);
        // Entry 5: slice 7 == 0x77, drop
        for (int s = 0; s < 8; s++) begin v[s] = '0; m[s] = '0; end
        v[7] = 32'h77; m[7] = '1;
        stage(v, m, 2'd0, 4'h0); cfg_write(5, 17, 32'd1);
        // Entry 1: slice 7 == 0x77 and slice 6 == BEEF, forward 1000
        v[6] = 32'hBEEF; m[6] = '1;
        stage(v, m, 2'd1, 4'h8); cfg_write(1, 17, 32'd1);
        // Entry 9: matches everything but disabled
        for (int s = 0; s < 8; s++) begin v[s] = '0; m[s] = '0; end
        stage(v, m, 2'd1, 4'hF); cfg_write(9, 17, 32'd0);

        for (int i = 0; i < 9; i++) begin
            logic [21:0] row;
            row = VEC[i];
            @(negedge clk);
            key_valid = 1'b1; key_data = key_of(int'(row[21:19]));
            exm_valid = 1'b1; exm_hit = row[18]; exm_kind = row[17:16]; exm_ports = row[15:12];
            @(posedge clk);
            @(negedge clk);
            key_valid = 1'b0; exm_valid = 1'b0;
            @(posedge clk); #1;
            check("R7 not yet", 64'(dec_valid), 64'd0);
            @(posedge clk); #1;
            check("R7 due", 64'(dec_valid), 64'd1);
            check(req_of(i), {dec_kind, dec_ports, dec_wild, dec_entry}, 64'(row[11:0]));
        end

        // Ordering: two keys, then exact results later
        @(negedge clk);
        key_valid = 1'b1; key_data = key_of(0);
        @(negedge clk);
        key_data = key_of(2);
        @(negedge clk);
        key_valid = 1'b0;
        seen = 0;
        for (int c = 0; c < 4; c++) begin
            @(posedge clk); #1;
            if (dec_valid) seen = 1;
        end
        check("R7 waits for exact result", 64'(seen), 64'd0);
        @(negedge clk);
        exm_valid = 1'b1; exm_hit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        exm_valid = 1'b0;
        collect(k, p, w, e);
        check("R7 first in order", {k, p, w, e}, {2'd1, 4'h5, 1'b1, 5'd3});
        collect(k, p, w, e);
        check("R7 second in order", {k, p, w, e}, {2'd0, 4'h0, 1'b1, 5'd5});

        cnt_read(3, rd);
        check("R9 entry 3 count, exact wins excluded", 64'(rd), 64'd2);
        cnt_read(1, rd);
        check("R9 entry 1 count", 64'(rd), 64'd2);
        cnt_read(5, rd);
        check("R9 entry 5 count", 64'(rd), 64'd2);
        cnt_read(9, rd);
        check("R3 disabled entry count", 64'(rd), 64'd0);

        // Staging for entry 2 without commit
        for (int s = 0; s < 8; s++) begin v[s] = '0; m[s] = '0; end
        v[7] = 32'h77; m[7] = '1;
        stage(v, m, 2'd1, 4'h1);
        send(key_of(2), 1'b0, 2'd0, 4'h0);
        collect(k, p, w, e);
        check("R12 staging not live", {k, p, w, e}, {2'd0, 4'h0, 1'b1, 5'd5});

        // Commit on the same edge as a lookup
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = {5'd2, 5'd17}; cfg_wdata = 32'd1;
        key_valid = 1'b1; key_data = key_of(2);
        exm_valid = 1'b1; exm_hit = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0; key_valid = 1'b0; exm_valid = 1'b0;
        collect(k, p, w, e);
        check("R11 same-edge lookup sees old", {k, p, w, e}, {2'd0, 4'h0, 1'b1, 5'd5});
        send(key_of(2), 1'b0, 2'd0, 4'h0);
        collect(k, p, w, e);
        check("R11 later lookup sees new", {k, p, w, e}, {2'd1, 4'h1, 1'b1, 5'd2});

        // Saturation and clear
        cfg_write(3, 18, 32'hFFFF_FFFE);
        cnt_read(3, rd);
        check("R10 load", 64'(rd), 64'hFFFF_FFFE);
        send(key_of(0), 1'b0, 2'd0, 4'h0);
        collect(k, p, w, e);
        send(key_of(0), 1'b0, 2'd0, 4'h0);
        collect(k, p, w, e);
        cnt_read(3, rd);
        check("R10 saturate", 64'(rd), 64'hFFFF_FFFF);
        cfg_write(3, 18, 32'd0);
        cnt_read(3, rd);
        check("R10 clear", 64'(rd), 64'd0);

        repeat (2) @(posedge clk);
        finish_up();
    end
endmodule